// File: doc/BRIEF.md
# Transmit Frame Assembler

This block builds one outgoing Ethernet frame from a series of 32-bit writes to a single data port. The first write after idle is a header word. Its low half gives the payload size, not counting the 14-byte MAC header. Its upper half already holds the first two frame bytes. Each later write adds four bytes. Once enough bytes have arrived, the block drops a CRC that software supplied, if any, and zero-fills frames that are too short. It then plays the frame out as a byte stream with valid, ready and last.

A sticky completion flag and a sticky rejection flag report the outcome, and each flag has its own acknowledge input. While a frame is streaming, the block raises a busy signal and accepts no further writes. After a rejected size word, the block discards all data writes until the rejection flag is acknowledged.

Top module: `txf_assembler`

## Requirements
- R1: After reset, `tx_valid`, `tx_last`, `wr_busy`, `irq_done` and `irq_err` are all 0, and the next accepted write is taken as a header word.
- R2: In a header word, bits 23:16 are frame byte 0 and bits 31:24 are frame byte 1. In each later word, bits 7:0 go out first and bits 31:24 go out last. Bytes leave in the order they arrived.
- R3: A header whose bits 15:0 exceed 2032 sets `irq_err` and starts no frame. All writes are then ignored, and `tx_valid` stays 0, until `ack_err` is asserted. The next write after that is a header word.
- R4: The target byte count is the header size plus 14, plus a further 4 when `cfg_auto_crc` is 0. `cfg_auto_crc` is sampled with the header word. The frame completes on the write that brings the collected count to or past the target.
- R5: When `cfg_auto_crc` was 0, the last 4 target bytes (the software CRC) are not sent. Any bytes written past the target are never sent either.
- R6: When `cfg_pad_en` is 1 in the completing cycle and the frame is shorter than 60 bytes, zero bytes extend it to exactly 60. Otherwise no bytes are added.
- R7: On completion, `irq_done` is set in the same cycle that streaming begins. It stays set until `ack_done` is asserted. A set event in the same cycle as an acknowledge wins over the acknowledge.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_last` hold. `tx_last` is 1 only with the final byte, and `tx_valid` drops after that byte is taken.
- R9: `wr_busy` is 1 while the frame streams out. Writes presented while it is 1 are ignored.
- R10: Asserting `ack_err` while a frame is being collected drops the partial frame, and the next write is a header word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Data-port write strobe |
| wr_data | input | 32 | Data-port write value |
| wr_busy | output | 1 | Frame streaming; writes are ignored |
| cfg_pad_en | input | 1 | Zero-fill short frames to 60 bytes |
| cfg_auto_crc | input | 1 | 1: CRC appended elsewhere; 0: software supplies it |
| ack_done | input | 1 | Clears `irq_done` |
| ack_err | input | 1 | Clears `irq_err` and abandons collection |
| irq_done | output | 1 | Sticky frame-complete flag |
| irq_err | output | 1 | Sticky oversize-rejection flag |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The bench runs a zero-size frame with and without padding. A design that miscounts the two header-word bytes would send 18 or 10 bytes instead of 14. It also runs frames whose software CRC falls inside the 60-byte pad region. A design that pads before dropping the CRC would leak nonzero CRC bytes where zeros belong. The largest accepted size (2032) and the smallest rejected size (2033) are both tried. An off-by-one limit would either refuse a legal frame or overrun the 2048-byte store. The bench also sends writes during rejection, during streaming and during an abandoned collection. A design that let any of these through would emit an extra frame or shift later bytes, and a random ready pattern would show any byte lost or repeated.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_LEN = 2'd0,
    ST_FILL     = 2'd1,
    ST_DRAIN    = 2'd2,
    ST_HALT     = 2'd3
  } asm_state_t;
endpackage

// File: rtl/txf_len_decode.sv
`timescale 1ns/1ps
module txf_len_decode #(
  parameter int MAX_BODY  = 2032,
  parameter int HDR_BYTES = 14,
  parameter int FCS_BYTES = 4,
  parameter int CNT_W     = 12
) (
  input  logic [15:0]      len_field,
  input  logic             auto_crc,
  output logic             too_long,
  output logic [CNT_W-1:0] target
);
  localparam logic [15:0]      LIMIT  = 16'(MAX_BODY);
  localparam logic [CNT_W-1:0] HDR_C  = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] FCS_C  = CNT_W'(FCS_BYTES);

  logic [CNT_W-1:0] body;

  always_comb begin
    too_long = len_field > LIMIT;
    // only meaningful when the size is in range; upper bits are then zero
    body     = too_long ? '0 : len_field[CNT_W-1:0];
    target   = body + HDR_C + (auto_crc ? '0 : FCS_C);
  end
endmodule

// File: rtl/txf_byte_store.sv
`timescale 1ns/1ps
module txf_byte_store #(
  parameter int BUF_BYTES = 2048,
  parameter int DW        = 32,
  parameter int CNT_W     = 12
) (
  input  logic               clk,
  input  logic               we,
  input  logic [DW/8-1:0]    lanes,
  input  logic [CNT_W-1:0]   base,
  input  logic [DW-1:0]      wdata,
  input  logic [CNT_W-1:0]   rd_addr,
  output logic [7:0]         rd_byte
);
  localparam int               LANES = DW / 8;
  localparam int               AW    = $clog2(BUF_BYTES);
  localparam logic [CNT_W-1:0] LIM   = CNT_W'(BUF_BYTES);

  logic [7:0]       mem [BUF_BYTES];
  logic [CNT_W-1:0] lane_addr [LANES];
  logic [LANES-1:0] lane_hit;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = base + CNT_W'(k);
    // writes beyond the store (tail of a software CRC) are dropped
    assign lane_hit[k]  = we && lanes[k] && (lane_addr[k] < LIM);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_hit[k]) mem[lane_addr[k][AW-1:0]] <= wdata[8*k +: 8];
    end
  end

  assign rd_byte = (rd_addr < LIM) ? mem[rd_addr[AW-1:0]] : 8'h00;
endmodule

// File: rtl/txf_stream.sv
`timescale 1ns/1ps
module txf_stream #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] send_len,
  input  logic [CNT_W-1:0] keep_len,
  output logic [CNT_W-1:0] rd_addr,
  input  logic [7:0]       rd_byte,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_last,
  output logic             finish
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] send_q, keep_q;
  logic             last_w;

  assign last_w = act_q && (idx_q == send_q - CNT_W'(1));

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (act_q && tx_ready) begin
      if (last_w) act_d = 1'b0;
      else        idx_d = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      send_q <= '0;
      keep_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      if (start) begin
        send_q <= send_len;
        keep_q <= keep_len;
      end
    end
  end

  assign rd_addr  = idx_q;
  // positions past the kept body are the zero fill
  assign tx_data  = (act_q && idx_q < keep_q) ? rd_byte : 8'h00;
  assign tx_valid = act_q;
  assign tx_last  = last_w;
  assign finish   = act_q && tx_ready && last_w;
endmodule

// File: rtl/txf_assembler.sv
`timescale 1ns/1ps
module txf_assembler
  import txf_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int MAX_BODY  = 2032,
  parameter int HDR_BYTES = 14,
  parameter int FCS_BYTES = 4,
  parameter int MIN_FRAME = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        wr_busy,
  input  logic        cfg_pad_en,
  input  logic        cfg_auto_crc,
  input  logic        ack_done,
  input  logic        ack_err,
  output logic        irq_done,
  output logic        irq_err,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_last
);
  localparam int               DW     = 32;
  localparam int               LANES  = DW / 8;
  localparam int               CNT_W  = $clog2(BUF_BYTES) + 1;
  localparam logic [CNT_W-1:0] FCS_C  = CNT_W'(FCS_BYTES);
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_FRAME);
  localparam logic [CNT_W-1:0] HEAD_C = CNT_W'(2);
  localparam logic [CNT_W-1:0] WORD_C = CNT_W'(LANES);

  asm_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, tgt_q, tgt_d;
  logic             fcs_q, fcs_d;
  logic             done_q, done_d, err_q, err_d;
  logic             cnt_en, set_done, set_err;

  logic             too_long;
  logic [CNT_W-1:0] dec_tgt;

  logic             st_we;
  logic [LANES-1:0] st_lanes;
  logic [CNT_W-1:0] st_base;

  logic             go;
  logic [CNT_W-1:0] fill_next, body_len, go_send;
  logic [CNT_W-1:0] rd_addr;
  logic [7:0]       rd_byte;
  logic             s_finish;

  txf_len_decode #(
    .MAX_BODY (MAX_BODY),
    .HDR_BYTES(HDR_BYTES),
    .FCS_BYTES(FCS_BYTES),
    .CNT_W    (CNT_W)
  ) u_dec (
    .len_field(wr_data[15:0]),
    .auto_crc (cfg_auto_crc),
    .too_long (too_long),
    .target   (dec_tgt)
  );

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    tgt_d     = tgt_q;
    fcs_d     = fcs_q;
    cnt_en    = 1'b0;
    st_we     = 1'b0;
    st_lanes  = '0;
    st_base   = cnt_q;
    go        = 1'b0;
    set_done  = 1'b0;
    set_err   = 1'b0;
    fill_next = cnt_q + WORD_C;
    body_len  = tgt_q - (fcs_q ? FCS_C : '0);
    go_send   = (cfg_pad_en && body_len < MIN_C) ? MIN_C : body_len;
    unique case (st_q)
      ST_WAIT_LEN: begin
        if (wr_valid) begin
          if (too_long) begin
            set_err = 1'b1;
            st_d    = ST_HALT;
          end else begin
            // upper half of the header word carries bytes 0 and 1
            st_we    = 1'b1;
            st_lanes = LANES'(4'b1100);
            st_base  = CNT_W'(0) - HEAD_C;
            cnt_en   = 1'b1;
            cnt_d    = HEAD_C;
            tgt_d    = dec_tgt;
            fcs_d    = !cfg_auto_crc;
            st_d     = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (ack_err) begin
          st_d = ST_WAIT_LEN;
        end else if (wr_valid) begin
          st_we    = 1'b1;
          st_lanes = '1;
          cnt_en   = 1'b1;
          cnt_d    = fill_next;
          if (fill_next >= tgt_q) begin
            go       = 1'b1;
            set_done = 1'b1;
            st_d     = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (s_finish) st_d = ST_WAIT_LEN;
      end
      ST_HALT: begin
        if (ack_err) st_d = ST_WAIT_LEN;
      end
      default: st_d = ST_WAIT_LEN;
    endcase
    done_d = set_done | (done_q & ~ack_done);
    err_d  = set_err  | (err_q  & ~ack_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAIT_LEN;
      cnt_q  <= '0;
      tgt_q  <= '0;
      fcs_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        tgt_q <= tgt_d;
        fcs_q <= fcs_d;
      end
    end
  end

  txf_byte_store #(
    .BUF_BYTES(BUF_BYTES),
    .DW       (DW),
    .CNT_W    (CNT_W)
  ) u_store (
    .clk    (clk),
    .we     (st_we),
    .lanes  (st_lanes),
    .base   (st_base),
    .wdata  (wr_data),
    .rd_addr(rd_addr),
    .rd_byte(rd_byte)
  );

  txf_stream #(
    .CNT_W(CNT_W)
  ) u_stream (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (go),
    .send_len(go_send),
    .keep_len(body_len),
    .rd_addr (rd_addr),
    .rd_byte (rd_byte),
    .tx_data (tx_data),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_last (tx_last),
    .finish  (s_finish)
  );

  assign wr_busy  = (st_q == ST_DRAIN);
  assign irq_done = done_q;
  assign irq_err  = err_q;
endmodule

// File: rtl/txf_assembler_chk.sv
`timescale 1ns/1ps
module txf_assembler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_busy,
  input logic       irq_done,
  input logic       irq_err,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_last
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_last_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);

  assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> !tx_valid);

  assert_done_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> irq_done);

  assert_busy_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> wr_busy);
endmodule

bind txf_assembler txf_assembler_chk u_chk (.*);

// File: tb/txf_assembler_bench.sv
`timescale 1ns/1ps
module txf_assembler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cfg_pad_en = 1'b0;
  logic        cfg_auto_crc = 1'b1;
  logic        ack_done = 1'b0;
  logic        ack_err = 1'b0;
  logic        tx_ready = 1'b1;
  logic        wr_busy, irq_done, irq_err, tx_valid, tx_last;
  logic [7:0]  tx_data;

  int total = 0;
  int bad = 0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  txf_assembler u_txf_assembler (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_busy(wr_busy), .cfg_pad_en(cfg_pad_en), .cfg_auto_crc(cfg_auto_crc),
    .ack_done(ack_done), .ack_err(ack_err), .irq_done(irq_done),
    .irq_err(irq_err), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         ms;
  logic [7:0] cq[$];
  logic [7:0] oq[$];
  int         mtarget;
  bit         mfcs, mdone, merr;

  always @(posedge clk or negedge rst_n) begin
    int  old;
    bit  sd, se;
    int  n;
    if (!rst_n) begin
      ms = 0; cq.delete(); oq.delete(); mdone = 0; merr = 0; mtarget = 0; mfcs = 0;
    end else begin
      old = ms; sd = 0; se = 0;
      if (old == 2 && tx_ready) begin
        void'(oq.pop_front());
        if (oq.size() == 0) ms = 0;
      end
      case (old)
        0: if (wr_valid) begin
             if (int'(wr_data[15:0]) > 2032) begin se = 1; ms = 3; end
             else begin
               mtarget = int'(wr_data[15:0]) + 14 + (cfg_auto_crc ? 0 : 4);
               mfcs = !cfg_auto_crc;
               cq.delete();
               cq.push_back(wr_data[23:16]);
               cq.push_back(wr_data[31:24]);
               ms = 1;
             end
           end
        1: if (ack_err) ms = 0;
           else if (wr_valid) begin
             for (int k = 0; k < 4; k++) cq.push_back(wr_data[8*k +: 8]);
             if (cq.size() >= mtarget) begin
               n = mtarget - (mfcs ? 4 : 0);
               oq.delete();
               for (int i = 0; i < n; i++) oq.push_back(cq[i]);
               if (cfg_pad_en) while (oq.size() < 60) oq.push_back(8'h00);
               sd = 1; ms = 2;
             end
           end
        3: if (ack_err) ms = 0;
        default: ;
      endcase
      mdone = sd | (mdone & !ack_done);
      merr  = se | (merr & !ack_err);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tx_valid == (ms == 2), "R8", "tx_valid", int'(tx_valid), int'(ms == 2));
      chk(wr_busy == (ms == 2), "R9", "wr_busy", int'(wr_busy), int'(ms == 2));
      chk(irq_done == mdone, "R7", "irq_done", int'(irq_done), int'(mdone));
      chk(irq_err == merr, "R3", "irq_err", int'(irq_err), int'(merr));
      if (ms == 2 && tx_valid && oq.size() > 0) begin
        chk(tx_data == oq[0], "R2", "tx_data", int'(tx_data), int'(oq[0]));
        chk(tx_last == (oq.size() == 1), "R8", "tx_last", int'(tx_last), int'(oq.size() == 1));
      end
    end
  end

  // sink side
  always @(negedge clk) tx_ready <= stall_mode ? ($urandom_range(0, 3) != 0) : 1'b1;

  int frames = 0;
  int cur = 0;
  logic [7:0] fr[$];
  logic [7:0] lastfr[$];
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      fr.push_back(tx_data);
      if (tx_last) begin
        lastfr = fr;
        fr.delete();
        frames++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  // ---------------- stimulus ----------------
  function automatic logic [7:0] pb(input int seed, input int i);
    return 8'(seed + i) | 8'h01;
  endfunction

  task automatic wr(input logic [31:0] d);
    while (wr_busy) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic push_frame(input int len, input bit crc, input bit pad, input int seed);
    int need, words;
    cfg_auto_crc = crc;
    cfg_pad_en   = pad;
    need  = len + 14 + (crc ? 0 : 4);
    words = (need - 2 + 3) / 4;
    wr({pb(seed, 1), pb(seed, 0), 16'(len)});
    for (int w = 0; w < words; w++)
      wr({pb(seed, 2+4*w+3), pb(seed, 2+4*w+2), pb(seed, 2+4*w+1), pb(seed, 2+4*w)});
  endtask

  task automatic run_frame(input int len, input bit crc, input bit pad, input int seed,
                           input int exp_n, input string req);
    int f0;
    f0 = frames;
    push_frame(len, crc, pad, seed);
    wait (frames == f0 + 1);
    @(negedge clk);
    chk(lastfr.size() == exp_n, req, "frame byte count", lastfr.size(), exp_n);
  endtask

  task automatic pulse_err();
    ack_err = 1'b1; @(negedge clk); ack_err = 1'b0;
  endtask

  task automatic pulse_done();
    ack_done = 1'b1; @(negedge clk); ack_done = 1'b0;
  endtask

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_valid && !tx_last, "R1", "stream idle", int'(tx_valid), 0);
    chk(!wr_busy, "R1", "busy", int'(wr_busy), 0);
    chk(!irq_done && !irq_err, "R1", "flags", int'(irq_done) + int'(irq_err), 0);

    // R4 zero payload: 14 bytes, R2 first byte from bits 23:16
    run_frame(0, 1'b1, 1'b0, 16, 14, "R4");
    chk(lastfr[0] == pb(16, 0), "R2", "first byte", int'(lastfr[0]), int'(pb(16, 0)));
    chk(lastfr[2] == pb(16, 2), "R2", "third byte", int'(lastfr[2]), int'(pb(16, 2)));
    // R6 pad zero payload to 60
    run_frame(0, 1'b1, 1'b1, 40, 60, "R6");
    chk(lastfr[59] == 8'h00, "R6", "pad byte", int'(lastfr[59]), 0);
    // R5 software CRC dropped, frame >= 60 so no pad
    run_frame(50, 1'b0, 1'b1, 70, 64, "R5");
    // R5/R6 CRC position must be zero-filled
    run_frame(30, 1'b0, 1'b1, 90, 60, "R5");
    chk(lastfr[44] == 8'h00, "R5", "crc slot zeroed", int'(lastfr[44]), 0);
    // R4 odd size overrun, no pad requested
    run_frame(31, 1'b1, 1'b0, 5, 45, "R4");
    // R7 done flag and acknowledge
    chk(irq_done, "R7", "done set", int'(irq_done), 1);
    pulse_done();
    chk(!irq_done, "R7", "done cleared", int'(irq_done), 0);

    // R3 rejection and ignored writes
    stall_mode = 1'b1;
    f0 = frames;
    wr(32'h0000_07F1);
    chk(irq_err, "R3", "error set", int'(irq_err), 1);
    wr(32'h0000_0000);
    wr(32'h1122_3344);
    wr(32'h5566_7788);
    repeat (4) @(negedge clk);
    chk(frames == f0 && !tx_valid, "R3", "no frame while halted", frames - f0, 0);
    pulse_err();
    chk(!irq_err, "R3", "error cleared", int'(irq_err), 0);
    run_frame(5, 1'b1, 1'b0, 120, 19, "R3");

    // R10 abandon collection
    wr(32'h0102_0064);
    wr(32'hAAAA_AAAA);
    wr(32'hBBBB_BBBB);
    pulse_err();
    run_frame(3, 1'b1, 1'b0, 60, 17, "R10");
    chk(lastfr[0] == pb(60, 0), "R10", "fresh header", int'(lastfr[0]), int'(pb(60, 0)));

    // R9 write during streaming is ignored
    f0 = frames;
    push_frame(100, 1'b1, 1'b0, 33);
    @(negedge clk);
    chk(wr_busy, "R9", "busy while streaming", int'(wr_busy), 1);
    wr_valid = 1'b1; wr_data = 32'hDEAD_0010;
    @(negedge clk);
    wr_valid = 1'b0;
    wait (frames == f0 + 1);
    @(negedge clk);
    chk(lastfr.size() == 114, "R9", "frame unaffected", lastfr.size(), 114);
    run_frame(2, 1'b1, 1'b0, 9, 16, "R9");

    // R4 largest accepted size, software CRC beyond the store
    run_frame(2032, 1'b0, 1'b0, 77, 2046, "R4");
    chk(!irq_err, "R3", "2032 accepted", int'(irq_err), 0);
    stall_mode = 1'b0;
    run_frame(60, 1'b1, 1'b1, 3, 74, "R6");

    repeat (5) @(negedge clk);
    summary();
  end
endmodule